// File: doc/BRIEF.md
# GPIO Bank Pin Register Block

This block holds the pin state of one general-purpose I/O bank of up to 32 pins: an output value per pin, a direction bit per pin and an output-enable bit per pin. It drives the pad output and pad tri-state enable signals. It also returns the pin levels to software. Software reaches it through a plain single-cycle register port. A write is taken on the rising clock edge while `reg_wr` is high. Read data is a combinational function of `reg_addr` and the current state. This port is control access, not a data stream, so it carries no valid/ready handshake and never stalls.

The output values are never written as a whole word. Each half of the bank has its own write-only register. In that register, the upper 16 bits of the written word are a per-pin keep mask and the lower 16 bits are the new values. Software can therefore change any subset of pins in one write, without a read-modify-write. The number of implemented pins and a set of pins that must always stay outputs are parameters.

Top module: `gpb_bank`

## Requirements
- R1: After reset, the output values and the stored direction and output-enable bits are 0. The direction register reads back only the forced-output pins as 1. Every pad enable is 0.
- R2: A write to address 0x000 updates pins 0..15 only. Pin i takes write bit i when write bit 16+i is 0, and keeps its value when write bit 16+i is 1.
- R3: A write to address 0x004 updates pins 16..31 only. Pin 16+i takes write bit i when write bit 16+i is 0, and keeps its value when write bit 16+i is 1.
- R4: Addresses 0x000 and 0x004 read as 0.
- R5: Address 0x060 is read-only and writes to it have no effect. Bit i of this register is the pin's output value when the pin is driven. Otherwise it is `pad_in[i]` delayed by SYNC_STAGES clock edges.
- R6: Address 0x204 is the direction register and is read-write. A bit value of 1 means output and 0 means input.
- R7: Address 0x208 is the output-enable register and is read-write.
- R8: `pad_oe[i]` is 1 exactly when direction bit i and output-enable bit i are both 1. `pad_out` carries the output values.
- R9: Bits at and above NUM_PINS read as 0 in every register, and writes to them are ignored.
- R10: Pins in FORCED_OUT always read 1 in the direction register, and a write of 0 to such a bit has no effect.
- R11: Any other address reads as 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad drive enables |

## Verification
A change of a pin's direction and a transition on the same pin's pad can fall in the same clock cycle. The read-back then has to switch its source from the output value to the synchronised pad, while the synchroniser still holds the old level. The bench provokes this by clearing a driven pin's direction bit in the same cycle that it raises that pin's pad. It judges the result by reading the level register one cycle and two cycles after the edge. The first read must show the old pad level and the second the new one, while every other pin keeps showing its output value.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned LANES  = REG_W / HALF_W;

  localparam logic [ADDR_W-1:0] OFS_SET_LO = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_SET_HI = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 12'h060;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h204;
  localparam logic [ADDR_W-1:0] OFS_OUTEN  = 12'h208;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SET_LO,
    SEL_SET_HI,
    SEL_LEVEL,
    SEL_DIR,
    SEL_OUTEN
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_SET_LO: s = SEL_SET_LO;
      OFS_SET_HI: s = SEL_SET_HI;
      OFS_LEVEL:  s = SEL_LEVEL;
      OFS_DIR:    s = SEL_DIR;
      OFS_OUTEN:  s = SEL_OUTEN;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic [REG_W-1:0] low_ones(input int unsigned n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpb_half_lane.sv
module gpb_half_lane #(
  parameter int unsigned        HW   = 16,
  parameter logic [HW-1:0]      IMPL = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [2*HW-1:0] wdata,
  output logic [HW-1:0]   val_q
);

  logic [HW-1:0] keep;
  logic [HW-1:0] fresh;
  logic [HW-1:0] nxt;

  assign keep  = wdata[2*HW-1:HW];
  assign fresh = wdata[HW-1:0];
  assign nxt   = ((val_q & keep) | (fresh & ~keep)) & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (wr_stb) val_q <= nxt;
  end

endmodule

// File: rtl/gpb_cfg_reg.sv
module gpb_cfg_reg #(
  parameter int unsigned   W      = 32,
  parameter logic [W-1:0]  IMPL   = '1,
  parameter logic [W-1:0]  FORCED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TIED = FORCED & IMPL;
  localparam logic [W-1:0] FREE = IMPL & ~FORCED;

  logic [W-1:0] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      store_q <= '0;
    else if (wr_stb) store_q <= wdata & FREE;
  end

  assign q = store_q | TIED;

  a_r6_r7_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(q));

endmodule

// File: rtl/gpb_bank.sv
module gpb_bank #(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] FORCED_OUT  = 32'h0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [gpb_pkg::ADDR_W-1:0]  reg_addr,
  input  logic                        reg_wr,
  input  logic [gpb_pkg::REG_W-1:0]   reg_wdata,
  output logic [gpb_pkg::REG_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0]         pad_in,
  output logic [NUM_PINS-1:0]         pad_out,
  output logic [NUM_PINS-1:0]         pad_oe
);
  import gpb_pkg::*;

  localparam logic [REG_W-1:0] IMPL_MASK = low_ones(NUM_PINS);

  reg_sel_e         sel;
  logic [REG_W-1:0] in_ext;
  logic [REG_W-1:0] in_sync;
  logic [REG_W-1:0] out_all;
  logic [REG_W-1:0] dir_q;
  logic [REG_W-1:0] oe_q;
  logic [REG_W-1:0] drive;
  logic [REG_W-1:0] level;

  assign sel = decode_addr(reg_addr);

  always_comb begin
    in_ext = '0;
    in_ext[NUM_PINS-1:0] = pad_in;
  end

  gpb_sync #(.W(REG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(in_ext), .sync_out(in_sync)
  );

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [HALF_W-1:0] lane_q;
      logic              lane_wr;
      assign lane_wr = reg_wr && (sel == ((k == 0) ? SEL_SET_LO : SEL_SET_HI));
      gpb_half_lane #(.HW(HALF_W), .IMPL(IMPL_MASK[k*HALF_W +: HALF_W])) u_lane (
        .clk(clk), .rst_n(rst_n), .wr_stb(lane_wr), .wdata(reg_wdata), .val_q(lane_q)
      );
      assign out_all[k*HALF_W +: HALF_W] = lane_q;
    end
  endgenerate

  gpb_cfg_reg #(.W(REG_W), .IMPL(IMPL_MASK), .FORCED(FORCED_OUT)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_stb(reg_wr && sel == SEL_DIR),
    .wdata(reg_wdata), .q(dir_q)
  );

  gpb_cfg_reg #(.W(REG_W), .IMPL(IMPL_MASK), .FORCED(32'h0)) u_oen (
    .clk(clk), .rst_n(rst_n), .wr_stb(reg_wr && sel == SEL_OUTEN),
    .wdata(reg_wdata), .q(oe_q)
  );

  assign drive = dir_q & oe_q;
  assign level = ((drive & out_all) | (~drive & in_sync)) & IMPL_MASK;

  assign pad_out = out_all[NUM_PINS-1:0];
  assign pad_oe  = drive[NUM_PINS-1:0];

  always_comb begin
    case (sel)
      SEL_LEVEL: reg_rdata = level;
      SEL_DIR:   reg_rdata = dir_q;
      SEL_OUTEN: reg_rdata = oe_q;
      default:   reg_rdata = '0;
    endcase
  end

  a_r2_low_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_SET_LO) |=>
      (((out_all[15:0] ^ $past(out_all[15:0])) & $past(reg_wdata[31:16])) == 16'h0));

  a_r3_high_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_SET_HI) |=>
      (((out_all[31:16] ^ $past(out_all[31:16])) & $past(reg_wdata[31:16])) == 16'h0));

  a_r11_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (sel == SEL_SET_LO || sel == SEL_SET_HI)) |=> $stable(out_all));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~IMPL_MASK) == '0);

endmodule

// File: tb/gpb_bank_test.sv
`timescale 1ns/1ps
module gpb_bank_test;

  localparam int unsigned NP     = 22;
  localparam logic [31:0] FRC    = 32'h0000_0180;
  localparam logic [31:0] IMPL   = 32'h003F_FFFF;
  localparam logic [11:0] A_LO   = 12'h000;
  localparam logic [11:0] A_HI   = 12'h004;
  localparam logic [11:0] A_LVL  = 12'h060;
  localparam logic [11:0] A_DIR  = 12'h204;
  localparam logic [11:0] A_OEN  = 12'h208;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model = '0;
  logic [31:0] v;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  always #10 clk = ~clk;

  gpb_bank #(.NUM_PINS(NP), .SYNC_STAGES(2), .FORCED_OUT(FRC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    #2 d = reg_rdata;
  endtask

  task automatic set_write(input logic hi, input logic [31:0] d);
    wr(hi ? A_HI : A_LO, d);
    for (int i = 0; i < 16; i++) begin
      if (!d[16+i]) model[(hi ? 16 : 0) + i] = d[i];
    end
    model = model & IMPL;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_LVL, v); chk("R1 level", v, 32'h0);
    rd(A_DIR, v); chk("R1 R10 dir", v, FRC);
    rd(A_OEN, v); chk("R1 outen", v, 32'h0);
    chk("R1 pad_oe", {10'h0, pad_oe}, 32'h0);
    chk("R1 pad_out", {10'h0, pad_out}, 32'h0);

    // R6 R7 R9 make all pins driven
    wr(A_DIR, 32'hFFFF_FFFF);
    wr(A_OEN, 32'hFFFF_FFFF);
    rd(A_DIR, v); chk("R6 R9 dir", v, IMPL);
    rd(A_OEN, v); chk("R7 R9 outen", v, IMPL);
    chk("R8 pad_oe all", {10'h0, pad_oe}, IMPL);

    // R2 R3 R9 per-pin sweep: set one pin at a time
    for (int p = 0; p < 32; p++) begin
      set_write(p >= 16, {~(16'h1 << (p % 16)), 16'hFFFF});
      rd(A_LVL, v); chk(p >= 16 ? "R3 R9 single" : "R2 single", v, model);
    end
    // keep-all writes change nothing
    set_write(1'b0, 32'hFFFF_0000);
    set_write(1'b1, 32'hFFFF_0000);
    rd(A_LVL, v); chk("R2 R3 keep all", v, model);
    chk("R8 pad_out", {10'h0, pad_out}, model);

    // R2 R3 pseudo-random mask/data sweep
    for (int n = 0; n < 256; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      set_write(lfsr[7], lfsr);
      rd(A_LVL, v); chk(lfsr[7] ? "R3 sweep" : "R2 sweep", v, model);
    end
    chk("R8 pad_out sweep", {10'h0, pad_out}, model);

    // R4 write-only registers read 0
    rd(A_LO, v); chk("R4 low reads 0", v, 32'h0);
    rd(A_HI, v); chk("R4 high reads 0", v, 32'h0);

    // concurrent: direction cleared on pin 3 while its pad rises (R5 R6)
    set_write(1'b0, 32'hFFF7_0000);
    @(negedge clk);
    reg_addr = A_DIR; reg_wdata = IMPL & ~32'h8; reg_wr = 1'b1; pad_in = 22'h8;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = A_LVL;
    #2 chk("R5 concurrent old pad", reg_rdata, model);
    @(negedge clk);
    #2 chk("R5 concurrent new pad", reg_rdata, model | 32'h8);
    chk("R8 pin3 undriven", {10'h0, pad_oe}, IMPL & ~32'h8);

    // R5 writes to level register ignored
    wr(A_DIR, 32'hFFFF_FFFF);
    wr(A_LVL, ~model);
    rd(A_LVL, v); chk("R5 level write ignored", v, model);
    chk("R5 pad_out unchanged", {10'h0, pad_out}, model);

    // R11 unmapped addresses
    wr(12'h20C, 32'h0);
    wr(12'h100, 32'h0);
    wr(12'h008, 32'h0);
    rd(12'h20C, v); chk("R11 unmapped read", v, 32'h0);
    rd(A_DIR, v);   chk("R11 dir kept", v, IMPL);
    rd(A_OEN, v);   chk("R11 outen kept", v, IMPL);
    rd(A_LVL, v);   chk("R11 out kept", v, model);

    // R5 R8 input path with output enable off
    wr(A_OEN, 32'h0);
    chk("R8 oe off", {10'h0, pad_oe}, 32'h0);
    for (int n = 0; n < 8; n++) begin
      logic [21:0] prev;
      logic [21:0] pat;
      prev = pad_in;
      pat = 22'(32'h0015_A3C7 * (n + 3) ^ (32'h3F << n));
      @(negedge clk);
      pad_in = pat; reg_addr = A_LVL;
      @(negedge clk);
      #2 chk("R5 sync lag", reg_rdata, {10'h0, prev});
      @(negedge clk);
      #2 chk("R5 sync level", reg_rdata, {10'h0, pat});
    end

    // R10 forced-output pins
    wr(A_DIR, 32'h0);
    rd(A_DIR, v); chk("R10 forced dir", v, FRC);
    wr(A_OEN, 32'hFFFF_FFFF);
    chk("R10 R8 forced drive", {10'h0, pad_oe}, FRC);
    rd(A_LVL, v);
    chk("R10 R5 mixed level", v, ((model & FRC) | ({10'h0, pad_in} & ~FRC)) & IMPL);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule